// File: doc/BRIEF.md
# Serial Result Readout Port

This block lets a host pull the latest 18-bit conversion result over a three-wire style serial link, at whatever pace the host chooses and with no tie to when results are produced. The host pulls an active-low frame select low. That captures the parallel result word into an output shift register and places the first bit on the serial data line before any serial clock edge arrives. Each falling edge of the host serial clock then advances the line to the next bit. The data driver is enabled only while the frame is selected. Pulling the select line high closes the frame at any point, including partway through a word.

Both host lines are asynchronous to the system clock, which must run at least four times faster than the serial clock. Each host line passes through a two-stage synchronizer and then an edge register. Every visible response therefore lands on the third rising system clock edge after the host line changes. The result word is packed with the overrange flag in bit 17, the polarity flag in bit 16 and the 16-bit magnitude in bits 15..0. Words leave the port in that bit order.

Top module: `rdport_serial_reader`

## Requirements
- R1: While reset is high, and after it is released with the select line high, `sdo_oe` is 0 and `sdo` is 0.
- R2: A high-to-low change of `rd_sel_n` captures `result`. On the third rising `clk` edge after that change, `sdo_oe` is 1 and `sdo` shows `result[17]` (overrange), with no serial clock edge needed.
- R3: Bits leave in the order `result[17]` (overrange), then `result[16]` (polarity), then `result[15]` down to `result[0]` (magnitude, MSB first).
- R4: Each high-to-low change of `sclk` during a frame advances `sdo` by exactly one bit on the third rising `clk` edge after it. A low-to-high change of `sclk` leaves `sdo` unchanged.
- R5: `sdo_oe` is 1 only inside a frame. It falls on the third rising `clk` edge after `rd_sel_n` rises. Whenever `sdo_oe` is 0, `sdo` is 0 (the driver is released).
- R6: Raising `rd_sel_n` partway through a word ends the frame. The next frame starts again from `result[17]` of a freshly captured word.
- R7: Once 18 falling `sclk` edges have been counted in a frame, `sdo` stays 0 until the frame ends, whatever further `sclk` edges arrive.
- R8: A change of `result` during a frame does not alter the bits still to be shifted. The new value appears only in the next frame.
- R9: `sclk` edges while `rd_sel_n` is high have no effect. The following frame still begins with `result[17]`, followed by `result[16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel_n | input | 1 | Active-low frame select from the host (asynchronous) |
| sclk | input | 1 | Host serial clock; falling edge advances the data (asynchronous) |
| result | input | 18 | Latest result: bit 17 overrange, bit 16 polarity, bits 15..0 magnitude |
| sdo | output | 1 | Serial data; 0 whenever the driver is released |
| sdo_oe | output | 1 | Output enable for an external tri-state pad driver |

## Verification
Each host line passes two synchronizer flops and an edge register. Every response to a change of `rd_sel_n` or `sclk` is therefore due on the third rising system clock edge after the change, and holds until the next host change. The driver alters one host line at a falling system clock edge and waits four rising edges. It then queues the expected `sdo` and `sdo_oe`. The monitor compares them at the next falling edge, and the next input change comes only after that. Each comparison therefore lands after the response is due and before anything can disturb it. Rising serial clock edges, mid-frame result changes and idle-time serial clock toggles get their own queued expectations, so a response that is absent is caught as surely as a wrong one.

// File: rtl/rdport_pkg.sv
package rdport_pkg;

    localparam int unsigned DEF_MAG_W       = 16;
    localparam int unsigned DEF_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2
    } edge_e;

    function automatic edge_e classify_edge(input logic prev, input logic cur);
        if (prev && !cur)      return EDGE_FALL;
        else if (!prev && cur) return EDGE_RISE;
        else                   return EDGE_NONE;
    endfunction

endpackage

// File: rtl/rdp_sync.sv
module rdp_sync
    import rdport_pkg::*;
#(
    parameter int unsigned STAGES  = DEF_SYNC_STAGES,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  d_async,
    output logic  level,
    output edge_e edge_kind
);

    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
            prev  <= RST_VAL;
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
            prev  <= chain[STAGES-1];
        end
    end

    assign level     = chain[STAGES-1];
    assign edge_kind = classify_edge(prev, chain[STAGES-1]);

endmodule

// File: rtl/rdp_frame_ctl.sv
module rdp_frame_ctl
    import rdport_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_MAG_W + 2
) (
    input  logic  clk,
    input  logic  rst,
    input  edge_e sel_edge,
    input  edge_e sck_edge,
    output logic  load,
    output logic  shift,
    output logic  active,
    output logic  drained
);

    localparam int unsigned CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(WORD_W);

    logic [CNT_W-1:0] cnt;
    logic             opening;
    logic             closing;

    assign opening = (sel_edge == EDGE_FALL);
    assign closing = (sel_edge == EDGE_RISE);
    assign load    = opening;
    assign shift   = active && !closing && (sck_edge == EDGE_FALL);
    assign drained = (cnt == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else begin
            if (opening) begin
                active <= 1'b1;
                cnt    <= '0;
            end else if (closing) begin
                active <= 1'b0;
            end else if (shift && cnt < CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assert_frame_open_R2: assert property (@(posedge clk) disable iff (rst)
        opening |=> active);

    assert_frame_close_R6: assert property (@(posedge clk) disable iff (rst)
        closing |=> !active);

    assert_idle_count_R9: assert property (@(posedge clk) disable iff (rst)
        (!active && !opening) |=> $stable(cnt));

    assert_count_cap_R7: assert property (@(posedge clk) disable iff (rst)
        drained |=> (cnt == CNT_MAX || $past(opening)));

endmodule

// File: rtl/rdp_shifter.sv
module rdp_shifter #(
    parameter int unsigned WORD_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift,
    input  logic [WORD_W-1:0] par_in,
    output logic              head_bit
);

    logic [WORD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
        end else if (load) begin
            shreg <= par_in;
        end else if (shift) begin
            shreg <= {shreg[WORD_W-2:0], 1'b0};
        end
    end

    assign head_bit = shreg[WORD_W-1];

    assert_hold_between_edges_R4: assert property (@(posedge clk) disable iff (rst)
        (!load && !shift) |=> $stable(shreg));

    assert_advance_one_R3: assert property (@(posedge clk) disable iff (rst)
        (shift && !load) |=> (head_bit == $past(shreg[WORD_W-2])));

endmodule

// File: rtl/rdport_serial_reader.sv
module rdport_serial_reader
    import rdport_pkg::*;
#(
    parameter int unsigned MAG_W       = DEF_MAG_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rd_sel_n,
    input  logic               sclk,
    input  logic [MAG_W+1:0]   result,
    output logic               sdo,
    output logic               sdo_oe
);

    localparam int unsigned WORD_W  = MAG_W + 2;
    localparam int unsigned N_LINES = 2;
    localparam logic [N_LINES-1:0] IDLE_LEVELS = 2'b01;   // [0] select idles high, [1] clock idles low

    logic [N_LINES-1:0] line_in;
    logic [N_LINES-1:0] line_lvl;
    edge_e              line_edge [N_LINES];

    assign line_in = {sclk, rd_sel_n};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        rdp_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (IDLE_LEVELS[g])
        ) u_sync (
            .clk       (clk),
            .rst       (rst),
            .d_async   (line_in[g]),
            .level     (line_lvl[g]),
            .edge_kind (line_edge[g])
        );
    end

    logic load;
    logic shift;
    logic active;
    logic drained;
    logic head_bit;

    rdp_frame_ctl #(
        .WORD_W (WORD_W)
    ) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .sel_edge (line_edge[0]),
        .sck_edge (line_edge[1]),
        .load     (load),
        .shift    (shift),
        .active   (active),
        .drained  (drained)
    );

    rdp_shifter #(
        .WORD_W (WORD_W)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .shift    (shift),
        .par_in   (result),
        .head_bit (head_bit)
    );

    assign sdo_oe = active;
    assign sdo    = active & head_bit;

    logic unused_levels;
    assign unused_levels = ^line_lvl;

    assert_first_bit_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (sdo_oe && sdo == $past(result[WORD_W-1])));

    assert_released_R5: assert property (@(posedge clk) disable iff (rst)
        (line_edge[0] == EDGE_RISE) |=> (!sdo_oe && !sdo));

    assert_drain_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (drained && sdo_oe) |-> !sdo);

    assert_stable_unselected_R9: assert property (@(posedge clk) disable iff (rst)
        (!sdo_oe && !load) |=> !sdo_oe);

endmodule

// File: tb/tb_rdport_serial_reader.sv
module tb_rdport_serial_reader;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         rd_sel_n = 1'b1;
    logic         sclk = 1'b0;
    logic [W-1:0] result = '0;
    logic         sdo;
    logic         sdo_oe;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    typedef struct {
        string tag;
        logic  e_sdo;
        logic  e_oe;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    rdport_serial_reader dut (
        .clk      (clk),
        .rst      (rst),
        .rd_sel_n (rd_sel_n),
        .sclk     (sclk),
        .result   (result),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        if (q.size() != 0) begin
            exp_t it;
            it = q.pop_front();
            checks++;
            if (sdo !== it.e_sdo || sdo_oe !== it.e_oe) begin
                errors++;
                $display("FAIL %s: sdo=%b sdo_oe=%b expected sdo=%b sdo_oe=%b",
                         it.tag, sdo, sdo_oe, it.e_sdo, it.e_oe);
            end
        end
    end

    // wait past the three-edge latency, queue expectation, let monitor consume it
    task automatic expect_after(string tag, logic e_sdo, logic e_oe);
        repeat (4) @(posedge clk);
        q.push_back('{tag, e_sdo, e_oe});
        @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic bit_at(logic [W-1:0] w, int idx);
        if (idx < W) return w[W-1-idx];
        return 1'b0;
    endfunction

    task automatic open_frame(logic [W-1:0] w, string tag);
        rd_sel_n = 1'b0;
        expect_after(tag, w[W-1], 1'b1);
    endtask

    // nfall falling sclk edges; pos is the index of the bit currently shown
    task automatic shift_bits(logic [W-1:0] w, int start, int nfall);
        for (int k = 0; k < nfall; k++) begin
            sclk = 1'b1;
            expect_after("R4 rising edge holds bit", bit_at(w, start + k), 1'b1);
            sclk = 1'b0;
            if (start + k + 1 >= W)
                expect_after("R7 drained shows zero", 1'b0, 1'b1);
            else
                expect_after("R3 bit order", bit_at(w, start + k + 1), 1'b1);
        end
    endtask

    task automatic close_frame(string tag);
        rd_sel_n = 1'b1;
        expect_after(tag, 1'b0, 1'b0);
    endtask

    initial begin
        logic [W-1:0] w1, w2, w3, w4;
        w1 = {1'b1, 1'b0, 16'hA5C3};
        w2 = {1'b0, 1'b1, 16'h0001};
        w3 = {1'b1, 1'b1, 16'h8000};
        w4 = {1'b0, 1'b0, 16'h7FFE};

        // R1: reset state
        result = w1;
        repeat (3) @(negedge clk);
        q.push_back('{"R1 during reset", 1'b0, 1'b0});
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        expect_after("R1 after reset", 1'b0, 1'b0);

        // R2, R3, R7: full word plus extra edges, then R5 close
        open_frame(w1, "R2 first bit before sclk");
        shift_bits(w1, 0, W + 2);
        close_frame("R5 released after frame");

        // second pattern
        result = w2;
        open_frame(w2, "R2 capture second word");
        shift_bits(w2, 0, W);
        close_frame("R5 released after second frame");

        // R6: abort mid-word, restart from overrange of new word
        result = w3;
        open_frame(w3, "R2 capture third word");
        shift_bits(w3, 0, 5);
        close_frame("R6 abort mid-word");
        result = w4;
        open_frame(w4, "R6 restart at overrange");
        shift_bits(w4, 0, 2);
        close_frame("R6 released");

        // R8: result changes inside a frame
        result = w1;
        open_frame(w1, "R2 capture before change");
        shift_bits(w1, 0, 3);
        result = w2;
        expect_after("R8 change ignored in frame", bit_at(w1, 3), 1'b1);
        shift_bits(w1, 3, W - 3);
        close_frame("R5 released after R8 frame");
        open_frame(w2, "R8 new value in next frame");
        shift_bits(w2, 0, 1);
        close_frame("R5 released");

        // R9: serial clock toggles outside a frame
        result = w3;
        for (int k = 0; k < 4; k++) begin
            sclk = 1'b1;
            expect_after("R9 idle rise ignored", 1'b0, 1'b0);
            sclk = 1'b0;
            expect_after("R9 idle fall ignored", 1'b0, 1'b0);
        end
        open_frame(w3, "R9 frame starts at overrange");
        sclk = 1'b1;
        expect_after("R9 rise keeps overrange", w3[W-1], 1'b1);
        sclk = 1'b0;
        expect_after("R9 polarity follows", w3[W-2], 1'b1);
        close_frame("R5 final release");

        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule